// File: doc/BRIEF.md
# Dual-Timing Multiplexed Bus Slave Port

This block lets a small register file sit on an 8-bit multiplexed address/data bus. Two families of bus control timing are supported, and a static mode pin picks one. In the low-mode ("strobe pair") style, the data strobe is an active-low read enable and R/W is an active-low write strobe. In the high-mode ("level plus strobe") style, R/W is a direction level and a high data strobe qualifies the data phase. All bus inputs are sampled on the internal clock through a synchroniser chain. The block then turns them into single-cycle read and write strobes, a latched address, the captured write data, and an enable for the external tri-state AD drivers.

The address is taken from the AD bus on each falling edge of the address strobe, whether or not chip enable is active. Reads and writes need chip enable low. While the active-low reset is held, every output is forced inactive and the bus is ignored. After release, strobes stay suppressed until the synchroniser holds only post-reset samples. Each bus-side change reaches the outputs `SYNC_STAGES + 1` clock edges later, which is 3 edges with the defaults.

Top module: `mbus_slave_if`

## Requirements
- R1: `moto_mode` = 1 selects level-plus-strobe timing and `moto_mode` = 0 selects strobe-pair timing. A stimulus that is a read or a write only in the other style produces no strobe and no `ad_oe`. Only a definite 1 selects level-plus-strobe timing, so an undriven pin gives strobe-pair timing.
- R2: On every falling edge of `as_in`, `addr_q` takes the value AD held while `as_in` was high, whatever `ce_n` is. It keeps that value until the next falling edge of `as_in`.
- R3: In strobe-pair timing with `ce_n` low, a falling edge of `ds_in` gives exactly one `rd_stb` pulse, one clock long. `ad_oe` stays high for as long as `ds_in` stays low.
- R4: In strobe-pair timing with `ce_n` low, nothing is written while `rw_in` is low. On the rising edge of `rw_in`, one `wr_stb` pulse appears with `wr_addr` = `addr_q` and `wr_data` = the AD value last sampled while `rw_in` was low.
- R5: In level-plus-strobe timing with `ce_n` low and `rw_in` high, a rising edge of `ds_in` gives one `rd_stb` pulse, and `ad_oe` is high while `ds_in` is high.
- R6: In level-plus-strobe timing with `ce_n` low and `rw_in` low, the falling edge of `ds_in` gives one `wr_stb` pulse, with `wr_data` = the AD value sampled during the data phase.
- R7: With `ce_n` high, no `rd_stb`, no `wr_stb` and no `ad_oe` appear, and `wr_addr`/`wr_data` keep their values.
- R8: `ad_oe` rises and falls exactly `SYNC_STAGES + 1` clock edges after the bus strobe that starts or ends the read, which is 3 edges by default.
- R9: While `rst_n` is low, `ad_oe`, `rd_stb` and `wr_stb` are 0 and `addr_q` is 0, and no bus activity is accepted. No strobe appears after release unless a new bus edge occurs.
- R10: When a write commit and an address-strobe fall are seen in the same cycle, `wr_addr` carries the address held before that fall, and `addr_q` takes the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal sampling clock |
| rst_n | input | 1 | Active-low reset, blocks access |
| moto_mode | input | 1 | Timing select: 1 level-plus-strobe, 0 strobe-pair |
| as_in | input | 1 | Address strobe, address taken on its fall |
| ds_in | input | 1 | Data strobe (read enable or data-phase qualifier) |
| rw_in | input | 1 | Write strobe or direction level, depending on mode |
| ce_n | input | 1 | Active-low chip enable |
| ad_in | input | DW | Multiplexed address/data bus, input side |
| addr_q | output | DW | Latched register address |
| rd_stb | output | 1 | One-cycle read strobe |
| wr_stb | output | 1 | One-cycle write strobe |
| wr_addr | output | DW | Address of the committed write |
| wr_data | output | DW | Data of the committed write |
| ad_oe | output | 1 | Enable for the external AD drivers |

## Verification
The address latch and the write commit can act in the same clock. This happens when a write strobe ends on the very cycle in which the next address strobe falls. A directed scenario drives a data word as the address, raises the address strobe while the write is still open, and then ends the write and drops the strobe at the same instant. The bench expects `wr_addr` to report the earlier address, `wr_data` the data word, and `addr_q` the new address. Any ordering fault between the latch and the commit shows up as a wrong `wr_addr`.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

  typedef enum logic {
    BUS_STROBE_PAIR = 1'b0,
    BUS_LEVEL_DS    = 1'b1
  } bus_mode_e;

  typedef struct packed {
    logic mode;
    logic as;
    logic ds;
    logic rw;
    logic ce_n;
  } bus_ctl_t;

  // Idle reset pattern of the control sync chain: mode low, AS low,
  // DS high, R/W high, chip enable off.
  localparam logic [4:0] CTL_IDLE = 5'b0_0111;

  // Only a definite high selects level-plus-strobe timing.
  function automatic bus_mode_e mode_from_pin(logic pin);
    if (pin) return BUS_LEVEL_DS;
    return BUS_STROBE_PAIR;
  endfunction

  function automatic logic read_level(bus_mode_e m, logic ds, logic rw);
    if (m == BUS_LEVEL_DS) return ds & rw;
    return ~ds;
  endfunction

  function automatic logic write_level(bus_mode_e m, logic ds, logic rw);
    if (m == BUS_LEVEL_DS) return ds & ~rw;
    return ~rw;
  endfunction

endpackage

// File: rtl/mbus_sync.sv
module mbus_sync #(
  parameter int             W       = 1,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  for (genvar i = 0; i < STAGES; i++) begin : g_stg
    logic [W-1:0] r;
    if (i == 0) begin : g_head
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r <= RST_VAL;
        else        r <= d;
      end
    end else begin : g_tail
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r <= RST_VAL;
        else        r <= g_stg[i-1].r;
      end
    end
  end

  assign q = g_stg[STAGES-1].r;

endmodule

// File: rtl/mbus_edge.sv
module mbus_edge
  import mbus_pkg::*;
#(
  parameter int DW     = 8,
  parameter int STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  bus_ctl_t      ctl_s,
  input  logic [DW-1:0] ad_s,
  output logic          live,
  output logic          read_lvl,
  output logic          write_lvl,
  output logic          ce_ok,
  output logic [DW-1:0] ad_p,
  output logic          as_fall,
  output logic          rd_rise,
  output logic          wr_fall
);

  localparam int VW = STAGES + 1;

  bus_mode_e   mode;
  logic        as_p, rd_p, wr_p;
  logic [VW-1:0] vld;

  always_comb begin
    mode      = mode_from_pin(ctl_s.mode);
    read_lvl  = read_level(mode, ctl_s.ds, ctl_s.rw);
    write_lvl = write_level(mode, ctl_s.ds, ctl_s.rw);
    ce_ok     = ~ctl_s.ce_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      as_p <= 1'b0;
      rd_p <= 1'b0;
      wr_p <= 1'b0;
      ad_p <= '0;
      vld  <= '0;
    end else begin
      as_p <= ctl_s.as;
      rd_p <= read_lvl;
      wr_p <= write_lvl;
      ad_p <= ad_s;
      vld  <= {vld[VW-2:0], 1'b1};
    end
  end

  assign live    = vld[VW-1];
  assign as_fall = live & as_p & ~ctl_s.as;
  assign rd_rise = live & read_lvl & ~rd_p;
  assign wr_fall = live & wr_p & ~write_lvl;

endmodule

// File: rtl/mbus_addr_latch.sv
module mbus_addr_latch #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          as_fall,
  input  logic [AW-1:0] ad_p,
  output logic [AW-1:0] addr_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (as_fall) addr_q <= ad_p;
  end

endmodule

// File: rtl/mbus_access.sv
module mbus_access #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          live,
  input  logic          read_lvl,
  input  logic          write_lvl,
  input  logic          ce_ok,
  input  logic          rd_rise,
  input  logic          wr_fall,
  input  logic [DW-1:0] ad_s,
  input  logic [DW-1:0] addr_q,
  output logic          rd_stb,
  output logic          wr_stb,
  output logic [DW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          ad_oe
);

  logic [DW-1:0] cap_data;
  logic          cap_ce;
  logic          commit;

  assign commit = wr_fall & cap_ce;

  // Follow the bus while the write is open; the last sample wins.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_data <= '0;
      cap_ce   <= 1'b0;
    end else if (write_lvl) begin
      cap_data <= ad_s;
      cap_ce   <= ce_ok;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_stb  <= 1'b0;
      wr_stb  <= 1'b0;
      ad_oe   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      rd_stb <= rd_rise & ce_ok;
      wr_stb <= commit;
      ad_oe  <= live & read_lvl & ce_ok;
      if (commit) begin
        wr_addr <= addr_q;
        wr_data <= cap_data;
      end
    end
  end

endmodule

// File: rtl/mbus_slave_if.sv
module mbus_slave_if
  import mbus_pkg::*;
#(
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          moto_mode,
  input  logic          as_in,
  input  logic          ds_in,
  input  logic          rw_in,
  input  logic          ce_n,
  input  logic [DW-1:0] ad_in,
  output logic [DW-1:0] addr_q,
  output logic          rd_stb,
  output logic          wr_stb,
  output logic [DW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          ad_oe
);

  localparam int CW = $bits(bus_ctl_t);

  bus_ctl_t      ctl_raw, ctl_s;
  logic [DW-1:0] ad_s, ad_p;
  logic          live, read_lvl, write_lvl, ce_ok;
  logic          as_fall, rd_rise, wr_fall;

  always_comb begin
    ctl_raw.mode = moto_mode;
    ctl_raw.as   = as_in;
    ctl_raw.ds   = ds_in;
    ctl_raw.rw   = rw_in;
    ctl_raw.ce_n = ce_n;
  end

  mbus_sync #(.W(CW), .STAGES(SYNC_STAGES), .RST_VAL(CTL_IDLE)) u_ctl_sync (
    .clk(clk), .rst_n(rst_n), .d(ctl_raw), .q(ctl_s)
  );

  mbus_sync #(.W(DW), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_ad_sync (
    .clk(clk), .rst_n(rst_n), .d(ad_in), .q(ad_s)
  );

  mbus_edge #(.DW(DW), .STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n), .ctl_s(ctl_s), .ad_s(ad_s),
    .live(live), .read_lvl(read_lvl), .write_lvl(write_lvl), .ce_ok(ce_ok),
    .ad_p(ad_p), .as_fall(as_fall), .rd_rise(rd_rise), .wr_fall(wr_fall)
  );

  mbus_addr_latch #(.AW(DW)) u_addr (
    .clk(clk), .rst_n(rst_n), .as_fall(as_fall), .ad_p(ad_p), .addr_q(addr_q)
  );

  mbus_access #(.DW(DW)) u_acc (
    .clk(clk), .rst_n(rst_n), .live(live), .read_lvl(read_lvl),
    .write_lvl(write_lvl), .ce_ok(ce_ok), .rd_rise(rd_rise), .wr_fall(wr_fall),
    .ad_s(ad_s), .addr_q(addr_q), .rd_stb(rd_stb), .wr_stb(wr_stb),
    .wr_addr(wr_addr), .wr_data(wr_data), .ad_oe(ad_oe)
  );

endmodule

// File: rtl/mbus_slave_if_chk.sv
module mbus_slave_if_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          as_fall,
  input logic          rd_stb,
  input logic          wr_stb,
  input logic          ad_oe,
  input logic [DW-1:0] addr_q,
  input logic [DW-1:0] wr_data
);

  AST_RD_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> !rd_stb); // R3

  AST_WR_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb); // R4

  AST_RD_WITH_OE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |-> ad_oe); // R3

  AST_ADDR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !as_fall |=> $stable(addr_q)); // R2

  AST_WDATA_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wr_data) |-> wr_stb); // R4

  AST_RESET_QUIET: assert property (@(posedge clk)
    (!rst_n && $past(!rst_n)) |-> (!ad_oe && !rd_stb && !wr_stb && addr_q == '0)); // R9

endmodule

bind mbus_slave_if mbus_slave_if_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .as_fall(as_fall), .rd_stb(rd_stb),
  .wr_stb(wr_stb), .ad_oe(ad_oe), .addr_q(addr_q), .wr_data(wr_data)
);

// File: tb/mbus_slave_if_tb.sv
module mbus_slave_if_tb;

  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          moto_mode = 1'b0;
  logic          as_in = 1'b0, ds_in = 1'b1, rw_in = 1'b1, ce_n = 1'b1;
  logic [DW-1:0] ad_in = '0;
  logic [DW-1:0] addr_q, wr_addr, wr_data;
  logic          rd_stb, wr_stb, ad_oe;

  int checks = 0, fails = 0, rd_cnt = 0, wr_cnt = 0, cyc = 0;
  logic [DW-1:0] last_wa = '0, last_wd = '0;
  bit done = 0;

  always #4 clk = ~clk;

  mbus_slave_if #(.DW(DW), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .moto_mode(moto_mode), .as_in(as_in),
    .ds_in(ds_in), .rw_in(rw_in), .ce_n(ce_n), .ad_in(ad_in),
    .addr_q(addr_q), .rd_stb(rd_stb), .wr_stb(wr_stb), .wr_addr(wr_addr),
    .wr_data(wr_data), .ad_oe(ad_oe)
  );

  // Pulse monitor, sampled away from the active edge.
  always @(negedge clk) begin
    if (rd_stb) rd_cnt++;
    if (wr_stb) begin
      wr_cnt++;
      last_wa = wr_addr;
      last_wd = wr_data;
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !done) begin
      checks++; fails++;
      $display("FAIL watchdog: got %0d cycles expected completion", cyc);
      summary();
      $finish;
    end
  end

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic go_reset(bit mode);
    rst_n = 1'b0;
    moto_mode = mode;
    as_in = 1'b0; rw_in = 1'b1; ds_in = mode ? 1'b0 : 1'b1;
    ce_n = 1'b1; ad_in = '0;
    step(3);
    rst_n = 1'b1;
    step(6);
  endtask

  task automatic latch(logic [DW-1:0] a);
    ad_in = a; as_in = 1'b1; step(4);
    as_in = 1'b0; step(4);
  endtask

  task automatic t_reset();
    int r0, w0;
    rst_n = 1'b0; ds_in = 1'b0; ce_n = 1'b0; ad_in = 8'h3F; as_in = 1'b1;
    step(3);
    as_in = 1'b0; step(4);
    check(ad_oe == 0, "R9", "ad_oe in reset", ad_oe, 0);
    check(addr_q == 0, "R9", "addr_q in reset", addr_q, 0);
    check(rd_cnt == 0 && wr_cnt == 0, "R9", "strobes in reset", rd_cnt + wr_cnt, 0);
    ds_in = 1'b1; ce_n = 1'b1;
    r0 = rd_cnt; w0 = wr_cnt;
    rst_n = 1'b1; step(8);
    check(rd_cnt == r0 && wr_cnt == w0, "R9", "strobes after release", rd_cnt + wr_cnt, r0 + w0);
  endtask

  task automatic t_sp_write();
    int w0;
    go_reset(0); ce_n = 1'b0;
    latch(8'h3C);
    check(addr_q == 8'h3C, "R2", "addr latched", addr_q, 8'h3C);
    w0 = wr_cnt;
    ad_in = 8'hA5; rw_in = 1'b0; step(5);
    check(wr_cnt == w0, "R4", "no write while R/W low", wr_cnt, w0);
    rw_in = 1'b1; step(5);
    check(wr_cnt == w0 + 1, "R4", "write count", wr_cnt, w0 + 1);
    check(last_wa == 8'h3C, "R4", "wr_addr", last_wa, 8'h3C);
    check(last_wd == 8'hA5, "R4", "wr_data", last_wd, 8'hA5);
    check(ad_oe == 0, "R4", "no oe on write", ad_oe, 0);
  endtask

  task automatic t_sp_read();
    int r0;
    latch(8'h51);
    r0 = rd_cnt;
    ds_in = 1'b0; step(2);
    check(ad_oe == 0, "R8", "oe before latency", ad_oe, 0);
    step(1);
    check(ad_oe == 1, "R8", "oe at latency", ad_oe, 1);
    step(10);
    check(ad_oe == 1, "R3", "oe held during DS low", ad_oe, 1);
    check(rd_cnt == r0 + 1, "R3", "one read pulse", rd_cnt, r0 + 1);
    check(addr_q == 8'h51, "R2", "read address", addr_q, 8'h51);
    ds_in = 1'b1; step(2);
    check(ad_oe == 1, "R8", "oe before release latency", ad_oe, 1);
    step(1);
    check(ad_oe == 0, "R8", "oe released", ad_oe, 0);
  endtask

  task automatic t_no_ce();
    int r0, w0;
    ce_n = 1'b1;
    latch(8'h77);
    check(addr_q == 8'h77, "R2", "addr latched with CE off", addr_q, 8'h77);
    ad_in = 8'h12; step(4);
    check(addr_q == 8'h77, "R2", "addr held after bus change", addr_q, 8'h77);
    r0 = rd_cnt; w0 = wr_cnt;
    ds_in = 1'b0; step(5);
    check(ad_oe == 0, "R7", "no oe with CE off", ad_oe, 0);
    ds_in = 1'b1; step(4);
    rw_in = 1'b0; step(4); rw_in = 1'b1; step(5);
    check(rd_cnt == r0 && wr_cnt == w0, "R7", "no strobes with CE off", rd_cnt + wr_cnt, r0 + w0);
    check(wr_data == 8'hA5, "R7", "wr_data kept", wr_data, 8'hA5);
    check(wr_addr == 8'h3C, "R7", "wr_addr kept", wr_addr, 8'h3C);
    ce_n = 1'b0;
  endtask

  task automatic t_same_cycle();
    int w0;
    latch(8'h21);
    w0 = wr_cnt;
    ad_in = 8'hC3; rw_in = 1'b0; step(4);
    as_in = 1'b1; step(4);
    rw_in = 1'b1; as_in = 1'b0; step(5);
    check(wr_cnt == w0 + 1, "R10", "write count", wr_cnt, w0 + 1);
    check(last_wa == 8'h21, "R10", "wr_addr is old address", last_wa, 8'h21);
    check(last_wd == 8'hC3, "R10", "wr_data", last_wd, 8'hC3);
    check(addr_q == 8'hC3, "R10", "addr_q is new address", addr_q, 8'hC3);
  endtask

  task automatic t_level_mode();
    int r0, w0;
    go_reset(1); ce_n = 1'b0;
    r0 = rd_cnt; w0 = wr_cnt;
    step(5);
    check(ad_oe == 0, "R1", "DS low is idle in level mode", ad_oe, 0);
    rw_in = 1'b0; step(4); rw_in = 1'b1; step(5);
    check(wr_cnt == w0 && rd_cnt == r0, "R1", "R/W toggle alone is no access", wr_cnt + rd_cnt, w0 + r0);
    latch(8'h90);
    rw_in = 1'b0; ad_in = 8'h5A; step(2); ds_in = 1'b1; step(5);
    check(wr_cnt == w0, "R6", "no write during data phase", wr_cnt, w0);
    ds_in = 1'b0; step(5);
    check(wr_cnt == w0 + 1, "R6", "write count", wr_cnt, w0 + 1);
    check(last_wa == 8'h90, "R6", "wr_addr", last_wa, 8'h90);
    check(last_wd == 8'h5A, "R6", "wr_data", last_wd, 8'h5A);
    rw_in = 1'b1; step(4);
    ds_in = 1'b1; step(3);
    check(ad_oe == 1, "R5", "oe on read phase", ad_oe, 1);
    step(5);
    check(rd_cnt == r0 + 1, "R5", "one read pulse", rd_cnt, r0 + 1);
    ds_in = 1'b0; step(3);
    check(ad_oe == 0, "R5", "oe released", ad_oe, 0);
  endtask

  task automatic t_reset_mid();
    int r0;
    go_reset(0); ce_n = 1'b0;
    ds_in = 1'b0; step(5);
    check(ad_oe == 1, "R9", "oe before reset", ad_oe, 1);
    rst_n = 1'b0; #1;
    check(ad_oe == 0, "R9", "oe drops on reset", ad_oe, 0);
    ds_in = 1'b1; step(3);
    r0 = rd_cnt;
    ds_in = 1'b0; step(4);
    check(rd_cnt == r0 && ad_oe == 0, "R9", "read ignored in reset", rd_cnt, r0);
    ds_in = 1'b1; step(2);
    rst_n = 1'b1; step(6);
  endtask

  initial begin
    t_reset();
    t_sp_write();
    t_sp_read();
    t_no_ce();
    t_same_cycle();
    t_level_mode();
    t_reset_mid();
    done = 1;
    summary();
    $finish;
  end

endmodule